// File: doc/BRIEF.md
# Strided MMIO Task-File Bridge

This block connects a host bus that addresses a 4 KB memory-mapped window to a disk controller's task-file register interface. The registers sit one every 16 bytes, so the register number is taken from address bits 11 down to 4. The host gives each access a width code. Byte accesses reach the seven task-file registers and the control/status register, which answers at two separate indices. Halfword and word accesses reach only the data register. Data passing through the data register is byte-reversed, because the host bus is big-endian and the device is little-endian.

Each accepted host access turns into at most one single-cycle read or write strobe on the device side, one clock later. Read data returns to the host one clock after the device strobe. An access that hits no register reaches the device as nothing. Such a read returns all ones at the access width, and such a write is dropped. A status read through either alias is presented to the device as a read of the alternate status register, so it leaves the device interrupt pending.

Top module: `mmio_taskfile_bridge`

## Requirements
- R1: The register index is host_addr[11:4]. Address bits above bit 11 and below bit 4 do not affect decoding.
- R2: A byte access (size code 0) at index 1 to 7 issues exactly one device strobe, one clock after the request, with dev_reg equal to the index and dev_size 0. dev_rd and dev_wr are never high together.
- R3: A byte write at index 8 or 22 issues a dev_wr with dev_reg 8 (device control) and dev_wdata equal to host_wdata[7:0] zero-extended.
- R4: A byte read at index 8 or 22 issues a dev_rd with dev_reg 8 (alternate status, which does not clear the interrupt). Its result is dev_rdata[7:0] zero-extended.
- R5: A byte access at any index other than 1 to 8 and 22 issues no strobe. Such a read returns 0x000000FF.
- R6: A halfword (size code 1) or word (size code 2) access at index 0 issues one strobe with dev_reg 0 and dev_size equal to the size code.
- R7: A halfword or word access at a nonzero index issues no strobe. Such a read returns 0x0000FFFF (halfword) or 0xFFFFFFFF (word).
- R8: On a data-register write, dev_wdata holds the bytes of host_wdata in reverse order: {w[7:0],w[15:8]} zero-extended for a halfword, {w[7:0],w[15:8],w[23:16],w[31:24]} for a word.
- R9: On a data-register read, host_rdata holds the bytes of dev_rdata in reverse order, using the same arrangement as R8 (halfword zero-extended).
- R10: host_rvalid pulses for one cycle, one clock after the read's device strobe slot, so two clocks after the request. No write ever raises host_rvalid.
- R11: Size code 3 is unmapped. A read with this code returns 0xFFFFFFFF, and a write with it is ignored.
- R12: While reset is held, dev_rd, dev_wr and host_rvalid are low and host_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Access request, one per cycle it is high |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 32 | Byte address within the window |
| host_size | input | 2 | Width code: 0 byte, 1 halfword, 2 word, 3 invalid |
| host_wdata | input | 32 | Write data, right-justified |
| host_rdata | output | 32 | Read result, right-justified |
| host_rvalid | output | 1 | Read result valid |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_reg | output | 4 | Device register: 0 data, 1-7 task file, 8 control / alternate status |
| dev_size | output | 2 | Width code of the device access |
| dev_wdata | output | 32 | Device write data, little-endian |
| dev_rdata | input | 32 | Device read data, sampled during dev_rd |

## Verification
The bench drives each request on a falling edge. It checks the device strobe, register code, width and write data at the next falling edge, which lies one rising edge after the request. At the falling edge after that it confirms the strobe has dropped, and it checks host_rvalid and host_rdata there, two rising edges after the request. The device model in the bench returns a pattern tied to the register code, so a result taken from the wrong register or with the wrong swap is detected.

// File: rtl/mmio_taskfile_bridge.sv
module mmio_taskfile_bridge #(
  parameter int ADDR_W      = 32,
  parameter int WIN_BITS    = 12,
  parameter int STRIDE_BITS = 4,
  parameter int REG_W       = 4,
  parameter int TF_LAST     = 7,
  parameter int CTL_ALIAS_A = 8,
  parameter int CTL_ALIAS_B = 22,
  parameter int CTL_CODE    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [1:0]        host_size,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_rvalid,
  output logic              dev_rd,
  output logic              dev_wr,
  output logic [REG_W-1:0]  dev_reg,
  output logic [1:0]        dev_size,
  output logic [31:0]       dev_wdata,
  input  logic [31:0]       dev_rdata
);
  localparam int IDX_W = WIN_BITS - STRIDE_BITS;
  localparam logic [IDX_W-1:0] TF_LAST_I = IDX_W'(TF_LAST);
  localparam logic [IDX_W-1:0] ALIAS_A_I = IDX_W'(CTL_ALIAS_A);
  localparam logic [IDX_W-1:0] ALIAS_B_I = IDX_W'(CTL_ALIAS_B);
  localparam logic [REG_W-1:0] CTL_CODE_I = REG_W'(CTL_CODE);

  function automatic logic [15:0] swap16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  function automatic logic [31:0] swap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  logic [IDX_W-1:0] idx;
  logic unused_addr_bits;
  assign idx = host_addr[WIN_BITS-1:STRIDE_BITS];
  assign unused_addr_bits = ^{host_addr[ADDR_W-1:WIN_BITS], host_addr[STRIDE_BITS-1:0]};

  logic is_tf, is_ctl, is_data, byte_hit, wide_hit, hit;
  assign is_tf    = (idx != '0) && (idx <= TF_LAST_I);
  assign is_ctl   = (idx == ALIAS_A_I) || (idx == ALIAS_B_I);
  assign is_data  = (idx == '0);
  assign byte_hit = (host_size == 2'd0) && (is_tf || is_ctl);
  assign wide_hit = ((host_size == 2'd1) || (host_size == 2'd2)) && is_data;
  assign hit      = byte_hit || wide_hit;

  logic [REG_W-1:0] reg_code;
  logic [31:0]      wdata_fmt;
  assign reg_code = is_ctl ? CTL_CODE_I : idx[REG_W-1:0];

  always_comb begin
    case (host_size)
      2'd0:    wdata_fmt = {24'h0, host_wdata[7:0]};
      2'd1:    wdata_fmt = {16'h0, swap16(host_wdata[15:0])};
      default: wdata_fmt = swap32(host_wdata);
    endcase
  end

  logic       rd_pend, miss_pend;
  logic [1:0] size_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_rd    <= 1'b0;
      dev_wr    <= 1'b0;
      dev_reg   <= '0;
      dev_size  <= 2'd0;
      dev_wdata <= '0;
      rd_pend   <= 1'b0;
      miss_pend <= 1'b0;
      size_q    <= 2'd0;
    end else begin
      dev_rd  <= host_valid && !host_write && hit;
      dev_wr  <= host_valid &&  host_write && hit;
      rd_pend <= host_valid && !host_write;
      if (host_valid) begin
        dev_reg   <= reg_code;
        dev_size  <= host_size;
        dev_wdata <= wdata_fmt;
        miss_pend <= !hit;
        size_q    <= host_size;
      end
    end
  end

  logic [31:0] fill, rdata_fmt;
  always_comb begin
    case (size_q)
      2'd0:    fill = 32'h0000_00FF;
      2'd1:    fill = 32'h0000_FFFF;
      default: fill = 32'hFFFF_FFFF;
    endcase
    case (size_q)
      2'd0:    rdata_fmt = {24'h0, dev_rdata[7:0]};
      2'd1:    rdata_fmt = {16'h0, swap16(dev_rdata[15:0])};
      default: rdata_fmt = swap32(dev_rdata);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= rd_pend;
      if (rd_pend) host_rdata <= miss_pend ? fill : rdata_fmt;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_rd && dev_wr)); // R2
  AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rd |=> host_rvalid); // R10
  AST_NO_RVALID_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr |=> !host_rvalid); // R10
  AST_ALT_STATUS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rd && dev_reg == CTL_CODE_I) |->
      ($past(idx) == ALIAS_A_I || $past(idx) == ALIAS_B_I)); // R4
  AST_DATA_IS_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ((dev_rd || dev_wr) && dev_reg == '0) |-> (dev_size == 2'd1 || dev_size == 2'd2)); // R6
  AST_WORD_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr && dev_size == 2'd2) |->
      dev_wdata == {$past(host_wdata[7:0]), $past(host_wdata[15:8]),
                    $past(host_wdata[23:16]), $past(host_wdata[31:24])}); // R8
  AST_SIZE3_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_size == 2'd3) |=> !(dev_rd || dev_wr)); // R11
endmodule

// File: tb/tb_mmio_taskfile_bridge.sv
module tb_mmio_taskfile_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0, host_write = 1'b0;
  logic [31:0] host_addr = '0, host_wdata = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_rdata, dev_wdata, dev_rdata;
  logic        host_rvalid, dev_rd, dev_wr;
  logic [3:0]  dev_reg;
  logic [1:0]  dev_size;
  logic [31:0] pat = 32'h1234_5678;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  assign dev_rdata = pat ^ {4{4'h0, dev_reg}};

  mmio_taskfile_bridge dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .dev_rd(dev_rd),
    .dev_wr(dev_wr), .dev_reg(dev_reg), .dev_size(dev_size),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sw32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] sw16(input logic [31:0] v);
    return {16'h0, v[7:0], v[15:8]};
  endfunction

  // expected mapping computed from R1-style rules per requirement
  function automatic logic exp_hit(input int idx, input logic [1:0] sz);
    if (sz == 2'd0) return (idx >= 1 && idx <= 7) || idx == 8 || idx == 22;
    if (sz == 2'd1 || sz == 2'd2) return idx == 0;
    return 1'b0;
  endfunction

  function automatic logic [3:0] exp_reg(input int idx);
    return (idx == 8 || idx == 22) ? 4'd8 : idx[3:0];
  endfunction

  task automatic access(input logic wr, input logic [31:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd);
    int idx = int'(addr[11:4]);
    logic h = exp_hit(idx, sz);
    logic [3:0] r = exp_reg(idx);
    logic [31:0] ewd, erd, rpat;
    string tag;
    tag = (sz == 2'd3) ? "R11" : (sz != 2'd0) ? (h ? "R6" : "R7") :
          (idx == 8 || idx == 22) ? (wr ? "R3" : "R4") : (h ? "R2" : "R5");
    ewd = (sz == 2'd0) ? {24'h0, wd[7:0]} : (sz == 2'd1) ? sw16(wd) : sw32(wd);
    rpat = pat ^ {4{4'h0, r}};
    if (!h) erd = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    else    erd = (sz == 2'd0) ? {24'h0, rpat[7:0]} : (sz == 2'd1) ? sw16(rpat) : sw32(rpat);
    host_valid = 1'b1; host_write = wr; host_addr = addr; host_size = sz; host_wdata = wd;
    @(negedge clk);
    host_valid = 1'b0;
    chk({tag, " rd strobe"}, {31'h0, dev_rd}, {31'h0, h && !wr});
    chk({tag, " wr strobe"}, {31'h0, dev_wr}, {31'h0, h && wr});
    if (h) begin
      chk({tag, " R1 dev_reg"}, {28'h0, dev_reg}, {28'h0, r});
      chk({tag, " dev_size"}, {30'h0, dev_size}, {30'h0, sz});
      if (wr) chk((sz == 2'd0) ? {tag, " wdata"} : "R8 wdata swap", dev_wdata, ewd);
    end
    @(negedge clk);
    chk("R2 strobe single cycle", {30'h0, dev_rd, dev_wr}, 32'h0);
    chk("R10 rvalid", {31'h0, host_rvalid}, {31'h0, !wr});
    if (!wr) chk((h && sz != 2'd0) ? "R9 rdata swap" : {tag, " rdata"}, host_rdata, erd);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R12 reset strobes", {30'h0, dev_rd, dev_wr}, 32'h0);
    chk("R12 reset rvalid", {31'h0, host_rvalid}, 32'h0);
    chk("R12 reset rdata", host_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 1; i <= 7; i++) access(1'b0, 32'(i) << 4, 2'd0, 32'h0);   // R2
    access(1'b1, 32'h0000_0030, 2'd0, 32'hDEAD_BEA5);                      // R2
    access(1'b0, 32'h0000_0080, 2'd0, 32'h0);                              // R4
    access(1'b0, 32'h0000_0160, 2'd0, 32'h0);                              // R4
    access(1'b1, 32'h0000_0160, 2'd0, 32'h0000_0006);                      // R3
    access(1'b1, 32'h0000_0080, 2'd0, 32'h1111_1102);                      // R3
    access(1'b0, 32'h0000_0000, 2'd0, 32'h0);                              // R5
    access(1'b0, 32'h0000_0090, 2'd0, 32'h0);                              // R5
    access(1'b1, 32'h0000_0FF0, 2'd0, 32'h55);                             // R5
    access(1'b1, 32'h0000_0000, 2'd1, 32'hAAAA_1234);                      // R8
    access(1'b1, 32'h0000_0000, 2'd2, 32'h0102_0304);                      // R8
    access(1'b0, 32'h0000_0000, 2'd1, 32'h0);                              // R9
    access(1'b0, 32'h0000_0000, 2'd2, 32'h0);                              // R9
    access(1'b0, 32'h0000_0010, 2'd1, 32'h0);                              // R7
    access(1'b0, 32'h0000_0020, 2'd2, 32'h0);                              // R7
    access(1'b1, 32'h0000_0010, 2'd2, 32'h0);                              // R7
    access(1'b0, 32'h0000_0000, 2'd3, 32'h0);                              // R11
    access(1'b1, 32'h0000_0010, 2'd3, 32'h77);                             // R11
    access(1'b0, 32'hFFFF_F03F, 2'd0, 32'h0);                              // R1
    access(1'b0, 32'h1234_500C, 2'd2, 32'h0);                              // R1
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a = $urandom;
      a[11:4] = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 24);
      pat = $urandom;
      access(1'($urandom), a, 2'($urandom), $urandom);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule